// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This cell is a small programmable logic element. It takes an 18-bit input bus and computes four outputs from a programmable AND plane. Each product term may use the true or the inverted form of any input. Each output has a choice of two paths:

- a short path that ORs only the four terms owned by that output;
- a wide path that ORs any subset of the twenty shared sum terms and then XORs the result with either a dedicated term or a fixed polarity bit.

Each output is either combinational or taken from its own flip-flop. Three further product terms can act as the flip-flop clock, a synchronous clear and an output-enable.

Configuration is loaded through a parallel word-write port. The port works only while `cfg_en` is high, and the flip-flops stay cleared for as long as `cfg_en` is high. The active-low `rst_n` clears the flip-flops and every configuration word, so the cell comes out of reset with all outputs low.

Top module: `pterm_cell`

## Requirements
- R1: Term word layout: bit k enables the true literal of `din[k]`, and bit 18+k enables its complement. A term is the AND of its enabled literals. A term with nothing enabled reads 1, and a term that enables both forms of one input reads 0.
- R2: Term word addresses are 0–19 for the sum terms, 20–23 for the XOR terms of outputs 0–3, and 24/25/26 for the clock, clear and enable terms. Output words are at 27–30 and the control word is at 31.
- R3: With output-word bit 1 set, output i is the OR of terms 4i..4i+3 and nothing else.
- R4: With bit 1 clear, output i is the OR of the sum terms whose bit 4+j (bits 23:4) is set, XORed with bit 3 (polarity) when bit 2 is clear.
- R5: With output-word bit 2 set, the XOR operand is XOR term i instead of the polarity bit.
- R6: Output-word bit 0 selects registered mode. In that mode the output keeps its value until the next rising `clk` edge, and it then shows the logic value that was present before that edge. With bit 0 clear the output follows `din` at once.
- R7: Control bit 0 set: the flip-flops load only at a `clk` edge where the clock term is 1 and was 0 at the previous edge.
- R8: Control bit 1 set: at any edge where the clear term is 1, the flip-flops clear instead of loading.
- R9: Control bit 2 set: `oe` equals the enable term, otherwise `oe` is 1. `ctl_pt` shows the raw {enable, clear, clock} terms as bits 2:0.
- R10: A low `rst_n` clears the flip-flops and all configuration words at once, so every output reads 0.
- R11: Writes made while `cfg_en` is low are ignored.
- R12: While `cfg_en` is high, every edge clears the flip-flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Active-low asynchronous global reset |
| cfg_en | input | 1 | Configuration mode; enables writes and holds flip-flops clear |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 36 | Configuration word data |
| din | input | 18 | Logic input bus |
| dout | output | 4 | Logic outputs |
| oe | output | 1 | Output-enable (term-driven or constant 1) |
| ctl_pt | output | 3 | Raw control terms {enable, clear, clock} |

## Verification
The assertions assume that `cfg_en` changes only between clock edges. They also assume that the control-term clock is a level which the global clock samples, not a free-running clock. The bench drives every input just after a falling edge and holds it for whole cycles. This keeps the clock term's rises and falls visible as distinct edge-to-edge samples. Configuration words are written only with `cfg_en` held high for the full cycle, except in the deliberate ignored-write test.

// File: rtl/pterm_cell.sv
module pterm_cell #(
  parameter int N_IN  = 18,
  parameter int N_OUT = 4,
  parameter int FAST  = 4,
  parameter int WIDE  = 20
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_en,
  input  logic                                   cfg_we,
  input  logic [$clog2(WIDE+2*N_OUT+4)-1:0]      cfg_addr,
  input  logic [2*N_IN-1:0]                      cfg_wdata,
  input  logic [N_IN-1:0]                        din,
  output logic [N_OUT-1:0]                       dout,
  output logic                                   oe,
  output logic [2:0]                             ctl_pt
);
  localparam int NT  = WIDE + N_OUT + 3;
  localparam int CK  = WIDE + N_OUT;
  localparam int RS  = CK + 1;
  localparam int OEP = CK + 2;
  localparam int CW  = NT + N_OUT;
  localparam int OCW = WIDE + 4;

  logic [NT-1:0][2*N_IN-1:0] tmask;
  logic [N_OUT-1:0][OCW-1:0] ocfg;
  logic [2:0]                ctl;
  logic [NT-1:0]             pt;
  logic [N_OUT-1:0]          comb, q;
  logic                      ck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmask <= '0;
      ocfg  <= '0;
      ctl   <= '0;
    end else if (cfg_en && cfg_we) begin
      if (int'(cfg_addr) < NT)
        tmask[int'(cfg_addr)] <= cfg_wdata;
      else if (int'(cfg_addr) < CW)
        ocfg[int'(cfg_addr) - NT] <= cfg_wdata[OCW-1:0];
      else if (int'(cfg_addr) == CW)
        ctl <= cfg_wdata[2:0];
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_term
    assign pt[t] = (&(~tmask[t][N_IN-1:0] | din)) & (&(~tmask[t][2*N_IN-1:N_IN] | ~din));
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic fsum, wsum, xop;
    assign fsum    = |pt[i*FAST +: FAST];
    assign wsum    = |(pt[WIDE-1:0] & ocfg[i][OCW-1:4]);
    assign xop     = ocfg[i][2] ? pt[WIDE+i] : ocfg[i][3];
    assign comb[i] = ocfg[i][1] ? fsum : (wsum ^ xop);
    assign dout[i] = ocfg[i][0] ? q[i] : comb[i];
  end

  logic load, clr;
  assign load = ~ctl[0] | (pt[CK] & ~ck_d);
  assign clr  = cfg_en | (ctl[1] & pt[RS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      ck_d <= 1'b0;
    end else begin
      ck_d <= pt[CK];
      if (clr)       q <= '0;
      else if (load) q <= comb;
    end
  end

  assign oe     = ~ctl[2] | pt[OEP];
  assign ctl_pt = {pt[OEP], pt[RS], pt[CK]};

  // R11
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable({tmask, ocfg, ctl}));

  // R12
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> q == '0);

  // R8
  ptrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && ctl[1] && pt[RS]) |=> q == '0);

  // R7
  ptclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !(ctl[1] && pt[RS]) && ctl[0] && !pt[CK]) |=> $stable(q));
endmodule

// File: tb/pterm_cell_tb.sv
module pterm_cell_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [35:0] cfg_wdata = '0;
  logic [17:0] din = '0;
  logic [3:0]  dout;
  logic        oe;
  logic [2:0]  ctl_pt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pterm_cell dut_i (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .din(din), .dout(dout),
    .oe(oe), .ctl_pt(ctl_pt));

  // {din, expected dout}: out0=(i0&i1)|~i2, out1=~(i4|(i5&~i6)), out2=i8^i7, out3=1
  localparam logic [21:0] VEC [10] = '{
    {18'h00000, 4'b1011}, {18'h00004, 4'b1010}, {18'h00007, 4'b1011},
    {18'h00014, 4'b1000}, {18'h00024, 4'b1000}, {18'h00064, 4'b1010},
    {18'h00084, 4'b1110}, {18'h00184, 4'b1010}, {18'h00105, 4'b1110},
    {18'h3FFFF, 4'b1001}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [35:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R10 reset dout", 32'(dout), 32'h0);
    chk("R9 reset oe", 32'(oe), 32'h1);
    chk("R1 empty terms", 32'(ctl_pt), 32'h7);
    @(negedge clk); rst_n = 1'b1;

    cfg_en = 1'b1;
    wr(5'd0, 36'h3);
    wr(5'd1, 36'h0_0010_0000);
    wr(5'd2, 36'h0_0020_0008);
    wr(5'd3, 36'h0_0020_0008);
    wr(5'd4, 36'h10);
    wr(5'd5, 36'h0_0100_0020);
    wr(5'd8, 36'h100);
    wr(5'd22, 36'h80);
    wr(5'd24, 36'h200);
    wr(5'd25, 36'h400);
    wr(5'd26, 36'h0_2000_0000);
    wr(5'd27, 36'h2);
    wr(5'd28, 36'h308);
    wr(5'd29, 36'h1004);
    wr(5'd30, 36'h10000);
    @(negedge clk); cfg_en = 1'b0;

    // R1 R2 R3 R4 R5: combinational table
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); din = VEC[k][21:4];
      #1 chk($sformatf("R3/R4/R5/R1 vec%0d", k), 32'(dout), 32'(VEC[k][3:0]));
    end

    // R11: write with cfg_en low is ignored
    wr(5'd30, 36'h0);
    wr(5'd31, 36'h4);
    @(negedge clk); din = 18'h00800; #1;
    chk("R11 out3 kept", 32'(dout[3]), 32'h1);
    chk("R11 ctl kept", 32'(oe), 32'h1);

    // R6: registered output
    cfg_en = 1'b1;
    wr(5'd29, 36'h1005);
    @(negedge clk); cfg_en = 1'b0; din = 18'h00100; #1;
    chk("R6 before edge", 32'(dout[2]), 32'h0);
    cyc(1);
    chk("R6 after edge", 32'(dout[2]), 32'h1);

    // R7: term clock
    cfg_en = 1'b1; din = 18'h0;
    wr(5'd31, 36'h1);
    @(negedge clk); cfg_en = 1'b0; din = 18'h00100;
    cyc(2);
    chk("R7 no rise", 32'(dout[2]), 32'h0);
    din = 18'h00300;
    cyc(1);
    chk("R7 rise loads", 32'(dout[2]), 32'h1);
    din = 18'h00200;
    cyc(2);
    chk("R7 high holds", 32'(dout[2]), 32'h1);
    din = 18'h00000;
    cyc(1);
    chk("R7 fall holds", 32'(dout[2]), 32'h1);
    din = 18'h00200;
    cyc(1);
    chk("R7 second rise", 32'(dout[2]), 32'h0);

    // R8: term clear
    cfg_en = 1'b1;
    wr(5'd31, 36'h2);
    @(negedge clk); cfg_en = 1'b0; din = 18'h00100;
    cyc(1);
    chk("R8 load", 32'(dout[2]), 32'h1);
    din = 18'h00500;
    cyc(1);
    chk("R8 clear", 32'(dout[2]), 32'h0);
    din = 18'h00100;
    cyc(1);
    chk("R8 reload", 32'(dout[2]), 32'h1);

    // R12: configuration mode clears flip-flops
    cfg_en = 1'b1;
    cyc(1);
    chk("R12 cfg clear", 32'(dout[2]), 32'h0);

    // R9: output enable term and raw terms
    wr(5'd31, 36'h4);
    @(negedge clk); cfg_en = 1'b0; din = 18'h00800; #1;
    chk("R9 oe low", 32'(oe), 32'h0);
    chk("R9 raw terms", 32'(ctl_pt), 32'h0);
    @(negedge clk); din = 18'h00400; #1;
    chk("R9 oe high", 32'(oe), 32'h1);
    chk("R9 raw terms 2", 32'(ctl_pt), 32'h6);

    // R10: global reset mid-run
    @(negedge clk); din = 18'h00007; #1;
    chk("R10 pre", 32'(dout[3]), 32'h1);
    rst_n = 1'b0; #1;
    chk("R10 reset clears", 32'(dout), 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule